// File: doc/BRIEF.md
# Edge-Triggered Interrupt Aggregator

This block gathers eleven level-valued request lines from the peripherals of a system and turns them into one processor request. For each line it keeps the level seen at the previous clock. A status bit is latched only in the cycle where its line goes from low to high. Software reads the latched bits at one register offset and enables sources at another. The processor request is a level that stays high while any latched bit is also enabled.

Software clears a status bit by writing 0 to it. Writing 1 leaves the bit as it is. A source whose line stays high after its bit is cleared does not raise the bit again. It has to drop the line and raise it again. An edge that arrives while its source is disabled is still latched, so enabling the source later raises the request.

The source positions are fixed, and the block treats every bit alike:

| Bit | Source |
|---|---|
| 0 | vertical blank |
| 1 | graphics |
| 2 | optical drive |
| 3 | DMA |
| 4 | timer 0 |
| 5 | timer 1 |
| 6 | timer 2 |
| 7 | controller / memory card |
| 8 | serial |
| 9 | audio |
| 10 | lightpen / parallel port |

Top module: `irq_aggregator`

## Requirements
- R1: After reset the status register, the mask register and the stored line levels are all zero. `cpuIrq` is low and both registers read as zero.
- R2: A line that was low at the previous clock edge and is high at this edge sets its status bit at this edge. The bit shows in the status read (offset 0x0, bit n = line n) from then on.
- R3: A line that stays high, stays low or falls never changes its status bit.
- R4: A write to offset 0x0 ANDs the status register with the written data. A 0 in a bit position clears that bit, and a 1 leaves it unchanged.
- R5: A line held high across a clearing write does not set its bit again. The bit is set again only after the line goes low for at least one cycle and then rises.
- R6: When a rising edge and a clearing write hit the same bit in the same cycle, the bit ends up set.
- R7: A write to offset 0x4 replaces the mask register with the low 11 bits of the write data. Offset 0x4 reads back the mask.
- R8: Only bits 10:0 of either register hold state, and bits 31:11 read as zero. Other offsets read as zero, and writes to them change nothing.
- R9: `cpuIrq` is high exactly when some bit is set in both the status and mask registers. It follows a change of either register in the same cycle the register changes.
- R10: An edge on a disabled source still latches its status bit without raising `cpuIrq`. Enabling that bit later raises `cpuIrq`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Active-low synchronous reset |
| irqLines | input | 11 | Request levels from the sources, synchronous to clk |
| regAddr | input | 4 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe for the current offset |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Read data for the current offset (combinational) |
| cpuIrq | output | 1 | Level request to the processor |

## Verification
A line edge or a register write takes effect at the rising clock edge where it is sampled. From that edge on, the new status or mask value shows on `regRdData`, and `cpuIrq` follows it with no further register delay. Read data depends only on the offset and register state, so it is valid in the same cycle the offset is presented. The bench changes inputs on the falling edge and advances its behavioural model at the rising edge. It compares the request output and the read data at the next falling edge, which is the first point where both are due.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  // Strobes from register decode to the datapath.
  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic selStatus;
    logic selMask;
  } regStrobe_t;

endpackage

// File: rtl/irq_agg_ctrl.sv
module irq_agg_ctrl
  import irq_agg_pkg::*;
#(
  parameter int ADDR_W     = 4,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  output regStrobe_t        strobe
);

  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(STATUS_OFS);
  localparam logic [ADDR_W-1:0] MASK_A   = ADDR_W'(MASK_OFS);

  logic hitStatus;
  logic hitMask;

  always_comb begin
    hitStatus        = (regAddr == STATUS_A);
    hitMask          = (regAddr == MASK_A);
    strobe.selStatus = hitStatus;
    strobe.selMask   = hitMask;
    strobe.wrStatus  = hitStatus && regWrEn;
    strobe.wrMask    = hitMask && regWrEn;
  end

endmodule

// File: rtl/irq_agg_dp.sv
module irq_agg_dp
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC = 11,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  regStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] wrData,
  output logic [DATA_W-1:0]  rdData,
  output logic               cpuIrq
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  logic [NUM_SRC-1:0] lineState;
  logic [NUM_SRC-1:0] riseEdge;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] maskQ;
  logic [NUM_SRC-1:0] keepBits;
  logic [NUM_SRC-1:0] rdBits;

  // Level seen on each line at the previous clock edge.
  always_ff @(posedge clk) begin
    if (!rstN) lineState <= '0;
    else       lineState <= irqLines;
  end

  // A clearing write lets through only the bits written as 1.
  assign keepBits = strobe.wrStatus ? wrData : {NUM_SRC{1'b1}};

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_src
    assign riseEdge[i] = irqLines[i] & ~lineState[i];

    // A new edge wins over a clear in the same cycle.
    always_ff @(posedge clk) begin
      if (!rstN) statusQ[i] <= 1'b0;
      else       statusQ[i] <= (statusQ[i] & keepBits[i]) | riseEdge[i];
    end

    a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rstN)
      (irqLines[i] && !lineState[i]) |=> statusQ[i]);

    a_r3_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
      (!statusQ[i] && !(irqLines[i] && !lineState[i])) |=> !statusQ[i]);

    a_r4_zero_clears: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrStatus && !wrData[i] && !(irqLines[i] && !lineState[i])) |=> !statusQ[i]);

    a_r4_one_keeps: assert property (@(posedge clk) disable iff (!rstN)
      (statusQ[i] && !(strobe.wrStatus && !wrData[i])) |=> statusQ[i]);

    a_r6_edge_beats_ack: assert property (@(posedge clk) disable iff (!rstN)
      (strobe.wrStatus && !wrData[i] && irqLines[i] && !lineState[i]) |=> statusQ[i]);
  end

  always_ff @(posedge clk) begin
    if (!rstN)            maskQ <= '0;
    else if (strobe.wrMask) maskQ <= wrData;
  end

  a_r7_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> (maskQ == $past(wrData)));

  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMask |=> $stable(maskQ));

  always_comb begin
    rdBits = '0;
    if (strobe.selStatus)    rdBits = statusQ;
    else if (strobe.selMask) rdBits = maskQ;
  end

  assign rdData = {{PAD_W{1'b0}}, rdBits};
  assign cpuIrq = |(statusQ & maskQ);

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
  import irq_agg_pkg::*;
#(
  parameter int NUM_SRC    = 11,
  parameter int ADDR_W     = 4,
  parameter int DATA_W     = 32,
  parameter int STATUS_OFS = 0,
  parameter int MASK_OFS   = 4
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] irqLines,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               cpuIrq
);

  regStrobe_t strobe;
  logic       unusedWrHi;

  assign unusedWrHi = ^regWrData[DATA_W-1:NUM_SRC];

  irq_agg_ctrl #(
    .ADDR_W    (ADDR_W),
    .STATUS_OFS(STATUS_OFS),
    .MASK_OFS  (MASK_OFS)
  ) i_ctrl (
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .strobe (strobe)
  );

  irq_agg_dp #(
    .NUM_SRC(NUM_SRC),
    .DATA_W (DATA_W)
  ) i_dp (
    .clk     (clk),
    .rstN    (rstN),
    .irqLines(irqLines),
    .strobe  (strobe),
    .wrData  (regWrData[NUM_SRC-1:0]),
    .rdData  (regRdData),
    .cpuIrq  (cpuIrq)
  );

endmodule

// File: tb/test_irq_aggregator.sv
`timescale 1ns/1ps
module test_irq_aggregator;

  localparam int N = 11;
  localparam int ALL = 'h7FF;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [10:0] irqLines = '0;
  logic [3:0]  regAddr = '0;
  logic        regWrEn = 1'b0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic        cpuIrq;

  int nCmp = 0;
  int nBad = 0;
  int mSt = 0;
  int mMk = 0;
  int mPrev = 0;
  string curReq = "R1";
  bit finished = 0;

  always #4 clk = ~clk;

  irq_aggregator i_irq_aggregator (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regAddr(regAddr),
    .regWrEn(regWrEn), .regWrData(regWrData), .regRdData(regRdData), .cpuIrq(cpuIrq)
  );

  task automatic check(string req, string what, longint act, longint exp);
    nCmp++;
    if (act != exp) begin
      nBad++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic int expRd(int a);
    if (a == 0) return mSt;
    if (a == 4) return mMk;
    return 0;
  endfunction

  // One clock: model advances at the rising edge, compare at the falling edge.
  task automatic cyc();
    int rise;
    @(posedge clk);
    if (rstN) begin
      rise = int'(irqLines) & ~mPrev & ALL;
      if (regWrEn && regAddr == 0) mSt = (mSt & int'(regWrData)) | rise;
      else                         mSt = mSt | rise;
      if (regWrEn && regAddr == 4) mMk = int'(regWrData) & ALL;
      mSt   = mSt & ALL;
      mPrev = int'(irqLines);
    end
    @(negedge clk);
    if (rstN) begin
      check(curReq, "cpuIrq", cpuIrq, (mSt & mMk) != 0);
      check(curReq, "regRdData", regRdData, expRd(int'(regAddr)));
    end
  endtask

  task automatic wr(int a, int d);
    regAddr = 4'(a); regWrEn = 1'b1; regWrData = 32'(d);
    cyc();
    regWrEn = 1'b0; regAddr = 4'd0;
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nCmp++; nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    regAddr = 4'd0; #1;
    check("R1", "status at reset", regRdData, 0);
    check("R1", "irq at reset", cpuIrq, 0);
    regAddr = 4'd4; #1;
    check("R1", "mask at reset", regRdData, 0);
    regAddr = 4'd0;
    rstN = 1'b1;
    cyc();

    // R7/R8: mask write with upper bits set
    curReq = "R7";
    wr(4, 32'hFFFF_F7FF);
    regAddr = 4'd4; cyc();
    check("R8", "mask upper bits zero", regRdData, 'h7FF);
    regAddr = 4'd0;

    // R2: single rising edge on bit 3
    curReq = "R2";
    irqLines[3] = 1'b1; cyc();
    check("R2", "bit3 latched", regRdData, 'h008);
    check("R9", "irq raised", cpuIrq, 1);

    // R3: held then falling
    curReq = "R3";
    repeat (3) cyc();
    irqLines[3] = 1'b0; repeat (2) cyc();
    check("R3", "fall keeps bit", regRdData, 'h008);

    // R4: write one keeps, write zero clears
    curReq = "R4";
    wr(0, ALL);
    cyc();
    check("R4", "ones keep", regRdData, 'h008);
    wr(0, ALL & ~'h008);
    check("R4", "zero clears", regRdData, 0);
    check("R9", "irq drops", cpuIrq, 0);

    // R5: held line not re-latched after ack
    curReq = "R5";
    irqLines[5] = 1'b1; cyc();
    wr(0, 0);
    repeat (3) cyc();
    check("R5", "held line stays clear", regRdData, 0);
    irqLines[5] = 1'b0; cyc();
    irqLines[5] = 1'b1; cyc();
    check("R5", "re-raised line latches", regRdData, 'h020);
    irqLines[5] = 1'b0; wr(0, 0);

    // R6: edge and clear in same cycle
    curReq = "R6";
    irqLines[7] = 1'b1; cyc();
    irqLines[7] = 1'b0; cyc();
    irqLines[7] = 1'b1;
    wr(0, 0);
    check("R6", "edge beats clear", regRdData, 'h080);
    irqLines[7] = 1'b0; wr(0, 0);

    // R10: masked edge latches, unmask raises
    curReq = "R10";
    wr(4, 0);
    irqLines[9] = 1'b1; cyc();
    check("R10", "masked bit latched", regRdData, 'h200);
    check("R10", "masked irq low", cpuIrq, 0);
    wr(4, 'h200);
    check("R10", "unmask raises irq", cpuIrq, 1);
    irqLines[9] = 1'b0;

    // R8: unmapped offset
    curReq = "R8";
    wr(8, ALL);
    regAddr = 4'd8; cyc();
    check("R8", "unmapped reads zero", regRdData, 0);
    regAddr = 4'd4; cyc();
    check("R8", "unmapped write ignored", regRdData, 'h200);
    regAddr = 4'd0;

    // R9/R2/R3: mixed line patterns with periodic clears and mask changes
    curReq = "R9";
    for (int k = 0; k < 120; k++) begin
      irqLines = 11'((k * 37) ^ (k >> 1) ^ (k << 3));
      if (k % 7 == 3)       wr(0, ~(k * 13));
      else if (k % 11 == 5) wr(4, k * 91);
      else begin
        regAddr = 4'((k % 3) * 4);
        cyc();
      end
    end

    finished = 1;
    summary();
  end

endmodule